// File: doc/BRIEF.md
# Click-Free Stereo Gain Commit Controller

This block holds the gain code for a stereo pair of analog gain stages and decides when a newly requested gain reaches each channel. A host presents a 7-bit gain code on a valid/ready write port. If smoothing is off, both channels take the code on the next clock. If smoothing is on, the left and right channels each wait for a zero crossing in their own sample stream. A crossing is looked for only on the cycles where the sample strobe is high. A channel that has not crossed by the time a shared timeout runs out is forced over to the new code.

The two channels commit independently. A fresh write restarts the shared timer and points both channels at the newest code. A channel still waiting therefore skips any code it never reached, and the two channels can differ for a while. A calibration-mute input pins both channels at the mute code. They stay muted after it drops until the next write. The write port never applies back-pressure: `wr_ready` is always high, and every cycle with `wr_valid` high counts as a write.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset both gain outputs read 00h (mute) and `done` is 1.
- R2: A write with `zc_en` = 0 and `cal_mute` = 0 appears on both `gain_l` and `gain_r` one clock later, and `done` stays 1.
- R3: A write with `zc_en` = 1 makes both channels pending. A pending channel takes the newest written code one clock after a strobe cycle in which its sample is zero, or has a sign bit (the MSB, two's complement) that differs from the sign bit of that channel's sample at the previous strobe. Before the first strobe after reset, the previous sign reads as non-negative. A crossing on one channel leaves the other channel unchanged.
- R4: If a channel is still pending at the Nth strobe after the most recent write, it takes the newest code one clock after that strobe. N is 256, 512, 1024 or 2048 for `tmo_sel` = 00, 01, 10 or 11.
- R5: A new write restarts the timeout count and retargets both channels. A channel still pending moves straight to the newest code, skipping the older one. A channel that had already committed keeps its value until its next crossing or the timeout.
- R6: While `cal_mute` is 1, both gain outputs are forced to 00h one clock later and writes are ignored. After `cal_mute` falls, both stay at 00h until the next write.
- R7: `done` is 0 while either channel is pending and 1 otherwise. Gain outputs change only after a write, a strobe or `cal_mute`.
- R8: `wr_ready` is 1 in every cycle, including during calibration mute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Gain write request |
| wr_ready | output | 1 | Always 1; the block never stalls a write |
| wr_gain | input | 7 | Requested gain code, 00h = mute |
| zc_en | input | 1 | 1 = commit on zero crossing or timeout, 0 = commit at once |
| tmo_sel | input | 2 | Timeout length select |
| smp_stb | input | 1 | One pulse per sample period |
| smp_l | input | SMP_W | Left sample, two's complement |
| smp_r | input | SMP_W | Right sample, two's complement |
| cal_mute | input | 1 | Calibration mute hold |
| gain_l | output | 7 | Active left gain code |
| gain_r | output | 7 | Active right gain code |
| done | output | 1 | No channel pending |

## Verification
The bench drives a sequence where the left channel crosses first and a second write then lands while the right channel is still waiting. A design that tied the channels together would move both on the first crossing. A design that kept the stale target would leave the right channel on the older code. Timeouts are checked one strobe before and exactly at the limit for the shortest and longest select, so an off-by-one counter or a wrong shift of the base shows up as an early or late commit. A second write partway through a timeout checks that the count restarts. Calibration mute is checked with a write issued during the mute, which must not leak through, and with the hold after the mute falls.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  localparam int GAIN_W = 7;
  localparam int NCH    = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;
  typedef logic [GAIN_W-1:0] gain_t;
  localparam gain_t GAIN_MUTE = '0;
endpackage

// File: rtl/zc_detect.sv
// Per-channel zero-crossing detector: sign change against the previous
// strobed sample, or an exact zero (R3).
module zc_detect #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [SMP_W-1:0] smp,
  output logic             zc
);
  logic prev_neg;
  logic cur_neg;
  logic is_zero;

  assign cur_neg = smp[SMP_W-1];
  assign is_zero = (smp == '0);
  assign zc      = stb & ((cur_neg != prev_neg) | is_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_neg <= 1'b0;
    else if (stb) prev_neg <= cur_neg;
  end
endmodule

// File: rtl/zc_timeout.sv
// Shared timeout counter: counts strobes from the last write while any
// channel is pending; limit is BASE shifted by the select code (R4, R5).
module zc_timeout #(
  parameter int BASE = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       active,
  input  logic       stb,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int CW = $clog2(BASE) + 4;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;

  assign limit_m1 = (CW'(BASE) << sel) - CW'(1);
  assign expire   = active & stb & ~restart & (cnt == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (expire)          cnt <= '0;
    else if (active && stb)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zc_gain_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int TMO_BASE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [6:0]       wr_gain,
  input  logic             zc_en,
  input  logic [1:0]       tmo_sel,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  input  logic             cal_mute,
  output logic [6:0]       gain_l,
  output logic [6:0]       gain_r,
  output logic             done
);
  logic [SMP_W-1:0] smp   [NCH];
  logic [NCH-1:0]   zc;
  logic [NCH-1:0]   pend;
  gain_t            gain  [NCH];
  gain_t            target;
  logic             wr_fire;
  logic             expire;

  assign wr_ready = 1'b1;                 // R8: no back-pressure
  assign wr_fire  = wr_valid & ~cal_mute; // R6: writes dropped in mute
  assign smp[CH_L] = smp_l;
  assign smp[CH_R] = smp_r;

  // Newest requested code, shared by both channels (R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       target <= GAIN_MUTE;
    else if (wr_fire) target <= wr_gain;
  end

  zc_timeout #(.BASE(TMO_BASE)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(wr_fire),
    .active (|pend),
    .stb    (smp_stb),
    .sel    (tmo_sel),
    .expire (expire)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zc_detect #(.SMP_W(SMP_W)) u_zc (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (smp_stb),
      .smp  (smp[c]),
      .zc   (zc[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain[c] <= GAIN_MUTE;               // R1
        pend[c] <= 1'b0;
      end else if (cal_mute) begin
        gain[c] <= GAIN_MUTE;               // R6
        pend[c] <= 1'b0;
      end else if (wr_fire) begin
        if (!zc_en) begin
          gain[c] <= wr_gain;               // R2
          pend[c] <= 1'b0;
        end else begin
          pend[c] <= 1'b1;                  // R3, R5
        end
      end else if (pend[c] && (zc[c] || expire)) begin
        gain[c] <= target;                  // R3, R4
        pend[c] <= 1'b0;
      end
    end
  end

  assign gain_l = gain[CH_L];
  assign gain_r = gain[CH_R];
  assign done   = ~|pend;                  // R7
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [6:0] wr_gain,
  input logic       zc_en,
  input logic       smp_stb,
  input logic       cal_mute,
  input logic [6:0] gain_l,
  input logic [6:0] gain_r,
  input logic       done
);
  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cal_mute && !zc_en) |=>
      (gain_l == $past(wr_gain) && gain_r == $past(wr_gain) && done)); // R2

  AST_SMOOTH_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cal_mute && zc_en) |=> !done); // R7

  AST_NO_STROBE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !wr_valid && !cal_mute) |=>
      ($stable(gain_l) && $stable(gain_r))); // R3

  AST_MUTE_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mute |=> (gain_l == 7'h00 && gain_r == 7'h00 && done)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_valid && !cal_mute) |=>
      ($stable(gain_l) && $stable(gain_r))); // R7
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_gain (wr_gain),
  .zc_en   (zc_en),
  .smp_stb (smp_stb),
  .cal_mute(cal_mute),
  .gain_l  (gain_l),
  .gain_r  (gain_r),
  .done    (done)
);

// File: tb/zc_gain_ctrl_tb_top.sv
`timescale 1ns/1ps
module zc_gain_ctrl_tb_top;
  localparam int SMP_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [6:0]       wr_gain = '0;
  logic             zc_en = 1'b0;
  logic [1:0]       tmo_sel = 2'b00;
  logic             smp_stb = 1'b0;
  logic [SMP_W-1:0] smp_l = '0;
  logic [SMP_W-1:0] smp_r = '0;
  logic             cal_mute = 1'b0;
  logic [6:0]       gain_l, gain_r;
  logic             done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zc_gain_ctrl #(.SMP_W(SMP_W), .TMO_BASE(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_gain(wr_gain), .zc_en(zc_en), .tmo_sel(tmo_sel), .smp_stb(smp_stb),
    .smp_l(smp_l), .smp_r(smp_r), .cal_mute(cal_mute),
    .gain_l(gain_l), .gain_r(gain_r), .done(done)
  );

  // Vector: wr, gain, zc_en, stb, smp_l, smp_r, exp_l, exp_r, exp_done
  localparam int VW = 57;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 7'h30, 1'b0, 1'b0, 16'sd0,   16'sd0,   7'h30, 7'h30, 1'b1}, // R2
    {1'b0, 7'h00, 1'b0, 1'b1, 16'sd100, 16'sd100, 7'h30, 7'h30, 1'b1}, // R7
    {1'b1, 7'h31, 1'b1, 1'b0, 16'sd0,   16'sd0,   7'h30, 7'h30, 1'b0}, // R3
    {1'b0, 7'h00, 1'b0, 1'b1, 16'sd50,  16'sd60,  7'h30, 7'h30, 1'b0}, // R3
    {1'b0, 7'h00, 1'b0, 1'b1, -16'sd5,  16'sd7,   7'h31, 7'h30, 1'b0}, // R3
    {1'b0, 7'h00, 1'b0, 1'b1, -16'sd4,  16'sd8,   7'h31, 7'h30, 1'b0}, // R3
    {1'b1, 7'h32, 1'b1, 1'b0, 16'sd0,   16'sd0,   7'h31, 7'h30, 1'b0}, // R5
    {1'b0, 7'h00, 1'b0, 1'b1, -16'sd3,  -16'sd1,  7'h31, 7'h32, 1'b0}, // R5
    {1'b0, 7'h00, 1'b0, 1'b1, 16'sd0,   -16'sd1,  7'h32, 7'h32, 1'b1}, // R3
    {1'b0, 7'h00, 1'b0, 1'b1, 16'sd5,   -16'sd2,  7'h32, 7'h32, 1'b1}, // R7
    {1'b1, 7'h10, 1'b1, 1'b0, 16'sd0,   16'sd0,   7'h32, 7'h32, 1'b0}, // R7
    {1'b0, 7'h00, 1'b0, 1'b1, -16'sd1,  16'sd3,   7'h10, 7'h10, 1'b1}  // R3
  };

  task automatic check(input bit ok, input string req,
                       input int al, input int ar, input int ad,
                       input int el, input int er, input int ed);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got L=%0h R=%0h done=%0d, expected L=%0h R=%0h done=%0d",
               req, al, ar, ad, el, er, ed);
    end
  endtask

  task automatic expect_out(input string req, input int el, input int er, input int ed);
    check(gain_l == 7'(el) && gain_r == 7'(er) && done == 1'(ed), req,
          gain_l, gain_r, done, el, er, ed);
  endtask

  // Called at a negedge: one write cycle, returns at the next negedge
  task automatic do_write(input logic [6:0] g, input logic en);
    wr_valid = 1'b1; wr_gain = g; zc_en = en;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic strobes(input int n, input logic [15:0] l, input logic [15:0] r);
    smp_l = l; smp_r = r; smp_stb = 1'b1;
    repeat (n) @(negedge clk);
    smp_stb = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got cycle %0d, expected under 100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_out("R1", 0, 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 1);
    check(wr_ready == 1'b1, "R8", wr_ready, 0, 0, 1, 0, 0);

    // Table walk: one vector per cycle
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      wr_valid = v[56]; wr_gain = v[55:49]; zc_en = v[48];
      smp_stb  = v[47]; smp_l = v[46:31]; smp_r = v[30:15];
      @(negedge clk);
      wr_valid = 1'b0; smp_stb = 1'b0;
      check(gain_l == v[14:8] && gain_r == v[7:1] && done == v[0],
            $sformatf("R3/R5 vector %0d", i),
            gain_l, gain_r, done, v[14:8], v[7:1], v[0]);
    end
    // Now: L last sign negative, R last sign positive; (-10, 10) never crosses.

    // R4: shortest timeout (256)
    tmo_sel = 2'b00;
    do_write(7'h50, 1'b1);
    strobes(255, -16'sd10, 16'sd10);
    expect_out("R4 256-1", 'h10, 'h10, 0);
    strobes(1, -16'sd10, 16'sd10);
    expect_out("R4 256", 'h50, 'h50, 1);

    // R5: restart of the timer by a second write
    do_write(7'h51, 1'b1);
    strobes(200, -16'sd10, 16'sd10);
    do_write(7'h52, 1'b1);
    strobes(200, -16'sd10, 16'sd10);
    expect_out("R5 restart", 'h50, 'h50, 0);
    strobes(55, -16'sd10, 16'sd10);
    expect_out("R5 restart-1", 'h50, 'h50, 0);
    strobes(1, -16'sd10, 16'sd10);
    expect_out("R5 skip", 'h52, 'h52, 1);

    // R4: longest timeout (2048)
    tmo_sel = 2'b11;
    do_write(7'h60, 1'b1);
    strobes(2047, -16'sd10, 16'sd10);
    expect_out("R4 2048-1", 'h52, 'h52, 0);
    strobes(1, -16'sd10, 16'sd10);
    expect_out("R4 2048", 'h60, 'h60, 1);

    // R7: no strobe, no movement while pending
    do_write(7'h20, 1'b1);
    repeat (5) @(negedge clk);
    expect_out("R7 idle-pending", 'h60, 'h60, 0);

    // R6: calibration mute with a write during the mute
    cal_mute = 1'b1;
    @(negedge clk);
    expect_out("R6 mute", 0, 0, 1);
    do_write(7'h33, 1'b0);
    expect_out("R6 write ignored", 0, 0, 1);
    check(wr_ready == 1'b1, "R8", wr_ready, 0, 0, 1, 0, 0);
    cal_mute = 1'b0;
    strobes(3, 16'sd0, 16'sd0);
    expect_out("R6 hold after", 0, 0, 1);
    do_write(7'h22, 1'b0);
    expect_out("R2 after mute", 'h22, 'h22, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule